// File: doc/BRIEF.md
# Multichannel Digital Silence Detector

This block watches the sample words of several audio channels, one word per channel in each frame, and drives an active-low silence flag. Each channel carries an inclusion bit. Channels whose bit is cleared are ignored. A static-mode input makes every channel count, whatever the mask holds. The flag goes low once every counted channel has delivered only zero words for a fixed run of consecutive frames, which is 9600 by default. It is also forced low for as long as the digital mute input is high.

A frame is marked by a one-cycle strobe that travels with the sample words. One shared run counter tracks how many quiet frames have passed in a row. A two-state machine sits on top of it. In `S_LIVE` the flag is high unless mute is active. The transition `RUN_REACHED` enters `S_QUIET` on the strobe that completes the run. In `S_QUIET` the flag is low. The transition `BREAK` returns to `S_LIVE` when a counted channel carries a nonzero word on a strobe, or when no channel is counted any more. Cycles without a strobe leave the run untouched.

Top module: `silence_watch`

## Requirements
- R1: After reset, on the clock edge that takes the RUN_LEN-th consecutive strobed frame in which every counted channel's word is all zeros, the flag goes low, and it is low in the cycle after that edge.
- R2: While fewer than RUN_LEN such consecutive frames have been taken, and mute is low, the flag stays high.
- R3: While mute is high, the flag is low in the same cycle, whatever the samples, mask or run state. Mute has no effect on the run counter.
- R4: A channel whose mask bit is 0 (bit i of the mask belongs to channel i, whose word is samples[i*SAMPLE_W +: SAMPLE_W]) is ignored: nonzero words on it neither break a run nor release the flag.
- R5: While static mode is high, all channels are counted regardless of the mask.
- R6: A strobed frame with a nonzero word on any counted channel clears the run. From the cycle after that edge, the flag is high unless mute is high.
- R7: Cycles without a frame strobe neither advance nor break the run, whatever the sample inputs hold.
- R8: Once reached, the run saturates: the flag stays low through any number of further quiet frames.
- R9: When no channel is counted (mask all zeros, static mode low), the run is cleared, and with mute low the flag is high.
- R10: After reset the flag is high (with mute low) and the run count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe marking a frame's sample words |
| samples | input | NUM_CH*SAMPLE_W | Sample words, channel i in bits [i*SAMPLE_W +: SAMPLE_W] |
| include_mask | input | NUM_CH | Per-channel inclusion bits |
| static_mode | input | 1 | Counts all channels, overriding the mask |
| mute | input | 1 | Digital mute state, forces the flag low |
| silence_n | output | 1 | Active-low silence flag |

## Verification
Full quiet runs are driven both with a strobe every cycle and with strobes mixed with idle cycles that carry noise. This separates counting frames from counting clocks. Noise placed only on excluded channels, with and without static mode, shows whether the mask and its override decide which channels can break a run. The boundary at RUN_LEN-1 versus RUN_LEN frames is checked, as are the saturation hold, the release on a single nonzero word, and the empty participation set. Random phases then mix sparse noise, mask changes and mute toggles against a bench model of the run count.

// File: rtl/silence_pkg.sv
package silence_pkg;
    typedef enum logic [0:0] {
        S_LIVE  = 1'b0,
        S_QUIET = 1'b1
    } sil_state_e;
endpackage

// File: rtl/chan_zero_detect.sv
module chan_zero_detect #(
    parameter int NUM_CH   = 6,
    parameter int SAMPLE_W = 24
) (
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    input  logic [NUM_CH-1:0]          include_mask,
    input  logic                       static_mode,
    output logic                       any_part,
    output logic                       frame_quiet
);
    logic [NUM_CH-1:0] eff_mask;
    logic [NUM_CH-1:0] loud;

    assign eff_mask = static_mode ? {NUM_CH{1'b1}} : include_mask;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        assign loud[i] = eff_mask[i] & (|samples[i*SAMPLE_W +: SAMPLE_W]);
    end

    assign any_part    = |eff_mask;
    assign frame_quiet = any_part & ~(|loud);
endmodule

// File: rtl/run_counter.sv
module run_counter #(
    parameter int RUN_LEN = 9600,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             frame_quiet,
    input  logic             any_part,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(RUN_LEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!any_part) begin
            cnt <= '0;
        end else if (frame_valid) begin
            if (!frame_quiet)   cnt <= '0;
            else if (cnt != TOP) cnt <= cnt + 1'b1;
        end
    end

    assert_sat_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (any_part && frame_valid && frame_quiet && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);

    assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_part && !frame_valid) |=> $stable(cnt));

    assert_break_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_quiet) |=> cnt == '0);
endmodule

// File: rtl/silence_fsm.sv
module silence_fsm
    import silence_pkg::*;
#(
    parameter int RUN_LEN = 9600,
    parameter int CNT_W   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             frame_quiet,
    input  logic             any_part,
    input  logic [CNT_W-1:0] cnt,
    input  logic             mute,
    output logic             silence_n
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    sil_state_e state_q, state_d;
    logic run_reached, brk;

    assign run_reached = any_part && frame_valid && frame_quiet && (cnt == LAST);
    assign brk         = !any_part || (frame_valid && !frame_quiet);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_LIVE:  if (run_reached) state_d = S_QUIET;
            S_QUIET: if (brk)         state_d = S_LIVE;
            default: state_d = S_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        silence_n = 1'b1;
        unique case (state_q)
            S_LIVE:  silence_n = !mute;
            S_QUIET: silence_n = 1'b0;
            default: silence_n = 1'b1;
        endcase
    end

    assert_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_reached |=> state_q == S_QUIET);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_quiet) |=> state_q == S_LIVE);

    assert_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_part |=> state_q == S_LIVE);

    assert_quiet_means_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_QUIET) |-> (cnt == LAST + 1'b1));
endmodule

// File: rtl/silence_watch.sv
module silence_watch #(
    parameter int NUM_CH   = 6,
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 9600
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    input  logic [NUM_CH-1:0]          include_mask,
    input  logic                       static_mode,
    input  logic                       mute,
    output logic                       silence_n
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic             any_part;
    logic             frame_quiet;
    logic [CNT_W-1:0] cnt;

    chan_zero_detect #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_detect (
        .samples     (samples),
        .include_mask(include_mask),
        .static_mode (static_mode),
        .any_part    (any_part),
        .frame_quiet (frame_quiet)
    );

    run_counter #(.RUN_LEN(RUN_LEN)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_valid(frame_valid),
        .frame_quiet(frame_quiet),
        .any_part   (any_part),
        .cnt        (cnt)
    );

    silence_fsm #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_valid(frame_valid),
        .frame_quiet(frame_quiet),
        .any_part   (any_part),
        .cnt        (cnt),
        .mute       (mute),
        .silence_n  (silence_n)
    );

    assert_mute_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> !silence_n);

    assert_static_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        static_mode |-> any_part);
endmodule

// File: tb/tb_silence_watch.sv
module tb_silence_watch;
    localparam int NUM_CH   = 6;
    localparam int SAMPLE_W = 24;
    localparam int RUN_LEN  = 9600;
    localparam int FW       = NUM_CH * SAMPLE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_valid = 1'b0;
    logic [FW-1:0]     samples = '0;
    logic [NUM_CH-1:0] include_mask = '1;
    logic              static_mode = 1'b0;
    logic              mute = 1'b0;
    logic              silence_n;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_cnt  = 0;
    string cur_req = "R10";

    always #4 clk = ~clk;

    silence_watch #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .samples(samples),
        .include_mask(include_mask), .static_mode(static_mode), .mute(mute),
        .silence_n(silence_n)
    );

    function automatic bit counted(input logic [NUM_CH-1:0] m, input logic st);
        return st ? 1'b1 : (m != '0);
    endfunction

    function automatic bit quiet_frame(input logic [FW-1:0] s, input logic [NUM_CH-1:0] m,
                                       input logic st);
        bit q = 1'b1;
        for (int i = 0; i < NUM_CH; i++)
            if ((st || m[i]) && (s[i*SAMPLE_W +: SAMPLE_W] != '0)) q = 1'b0;
        return q;
    endfunction

    function automatic logic exp_flag(input int c, input logic mu);
        return !(mu || c == RUN_LEN);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: silence_n=%b expected %b (run=%0d)", req, act, exp, exp_cnt);
        end
    endtask

    task automatic apply(input logic fv, input logic [FW-1:0] s, input logic [NUM_CH-1:0] m,
                         input logic st, input logic mu);
        @(negedge clk);
        frame_valid = fv; samples = s; include_mask = m; static_mode = st; mute = mu;
        #1 check({cur_req, " same-cycle"}, silence_n, exp_flag(exp_cnt, mu));
        @(posedge clk);
        if (!counted(m, st)) exp_cnt = 0;
        else if (fv) begin
            if (!quiet_frame(s, m, st)) exp_cnt = 0;
            else if (exp_cnt < RUN_LEN) exp_cnt++;
        end
        #2 check(cur_req, silence_n, exp_flag(exp_cnt, mu));
    endtask

    function automatic logic [FW-1:0] noise_on(input int ch);
        logic [FW-1:0] s = '0;
        s[ch*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'($urandom_range(1, 255)) << $urandom_range(0, SAMPLE_W-8);
        return s;
    endfunction

    function automatic logic [FW-1:0] all_noise();
        logic [FW-1:0] s;
        for (int i = 0; i < NUM_CH; i++) s[i*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'($urandom());
        return s;
    endfunction

    task automatic quiet_run(input int frames, input logic [NUM_CH-1:0] m, input logic st,
                             input logic [FW-1:0] side, input bit gaps);
        for (int k = 0; k < frames; k++) begin
            if (gaps && ($urandom_range(0, 3) == 0)) apply(1'b0, all_noise(), m, st, 1'b0);
            apply(1'b1, side, m, st, 1'b0);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1 check("R10 reset flag", silence_n, 1'b1);
        @(negedge clk); rst_n = 1'b1;

        // R2 then R1: full mask, strobes with noisy idle gaps (R7)
        cur_req = "R2"; quiet_run(RUN_LEN - 1, '1, 1'b0, '0, 1'b1);
        #1 check("R2 one frame short", silence_n, 1'b1);
        cur_req = "R1"; apply(1'b1, '0, '1, 1'b0, 1'b0);
        check("R1 run complete", silence_n, 1'b0);
        // R8: saturation keeps flag low
        cur_req = "R8"; quiet_run(200, '1, 1'b0, '0, 1'b0);
        check("R8 saturated", silence_n, 1'b0);
        // R7: idle noise does not break
        cur_req = "R7";
        for (int k = 0; k < 20; k++) apply(1'b0, all_noise(), '1, 1'b0, 1'b0);
        check("R7 idle noise ignored", silence_n, 1'b0);
        // R6: one nonzero word on channel 3 releases
        cur_req = "R6"; apply(1'b1, noise_on(3), '1, 1'b0, 1'b0);
        check("R6 release", silence_n, 1'b1);
        // R3: mute forces low regardless
        cur_req = "R3";
        for (int k = 0; k < 10; k++) apply(1'b1, all_noise(), '1, 1'b0, 1'b1);
        check("R3 mute low", silence_n, 1'b0);
        apply(1'b1, all_noise(), '1, 1'b0, 1'b0);
        check("R3 mute off", silence_n, 1'b1);

        // R4: channel 0 excluded and noisy, strobe every cycle
        cur_req = "R4"; quiet_run(RUN_LEN, 6'b111110, 1'b0, noise_on(0), 1'b0);
        check("R4 excluded channel ignored", silence_n, 1'b0);
        apply(1'b1, noise_on(0), 6'b111110, 1'b0, 1'b0);
        check("R4 still low", silence_n, 1'b0);

        // R9: empty participation releases and holds high
        cur_req = "R9";
        for (int k = 0; k < 30; k++) apply(1'b1, '0, '0, 1'b0, 1'b0);
        check("R9 no channel counted", silence_n, 1'b1);

        // R5: static mode with empty mask counts everything
        cur_req = "R5"; quiet_run(RUN_LEN, '0, 1'b1, '0, 1'b0);
        check("R5 static run", silence_n, 1'b0);
        apply(1'b1, noise_on(5), '0, 1'b1, 1'b0);
        check("R5 static release", silence_n, 1'b1);

        // random mix checked against the model
        cur_req = "R6 random";
        for (int k = 0; k < 4000; k++) begin
            logic [FW-1:0] s = ($urandom_range(0, 40) == 0) ? noise_on($urandom_range(0, NUM_CH-1)) : '0;
            logic [NUM_CH-1:0] m = ($urandom_range(0, 50) == 0) ? NUM_CH'($urandom()) : 6'b111111;
            apply($urandom_range(0, 2) != 0, s, m, $urandom_range(0, 9) == 0, $urandom_range(0, 30) == 0);
        end
        summary();
    end
endmodule